// File: doc/BRIEF.md
# PLL Control Register Commit Unit

This block sits between a simple synchronous register bus and a clock-generator PLL. Software writes staging copies of two bytes. The control byte carries the enable and connect flags. The configuration byte carries a multiplier and a divider. The staged values do nothing on their own. They reach the PLL pins only when a two-write unlock sequence (a "feed") completes on a dedicated address. This guards the clock tree against a single stray write.

The committed enable, multiplier and divider drive the PLL directly. A registered select output steers an external glitch-free clock mux. The select chooses the PLL output only when both enable and connect are committed as one; otherwise it chooses the oscillator. The PLL lock flag is an input that software can read back. It never gates the connection and never forces a disconnect.

Readback of the control and configuration addresses returns the committed values, not the staged ones. A status word gathers all committed fields together with the lock input.

Top module: `pll_commit_unit`

## Requirements
- R1: The address map is: address 0 = control, address 1 = configuration, address 2 = feed, address 3 = status. In the control byte, bit 0 is enable and bit 1 is connect. In the configuration byte, bits 4:0 are the multiplier and bits 6:5 are the divider.
- R2: A write to control or configuration changes neither the PLL outputs nor the readback until a feed commits it.
- R3: A feed commits both staged bytes at the clock edge that accepts the second key. The feed is a write of 0xAA to address 2, followed by a write of 0x55 to address 2 as the next bus access. Idle cycles between the two writes are allowed. Repeating 0xAA re-arms the sequence.
- R4: A feed is aborted, and nothing is committed, when any of the following happens: a different data value at address 2, any read, any write to another address between the two keys, or a 0x55 write without a preceding 0xAA.
- R5: `pll_en_o`, `pll_mul_o` and `pll_div_o` equal the committed enable, multiplier and divider.
- R6: `clk_sel_o` becomes 1 one cycle after a commit that leaves both enable and connect at one. Otherwise it is 0.
- R7: `lock_i` has no effect on `clk_sel_o` or on any committed field.
- R8: After reset, all committed and staged fields are zero and `clk_sel_o` is 0.
- R9: Reads return data combinationally from `addr_i`, as follows:
  - Control reads give {0, connect, enable}.
  - Configuration reads give {0, divider, multiplier}.
  - Status reads give lock in bit 9, divider in bits 8:7, multiplier in bits 6:2, connect in bit 1 and enable in bit 0.
  - Reserved bits read as zero, and a read of address 2 returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus and register clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 2 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 16 | Read data |
| lock_i | input | 1 | PLL lock status |
| pll_en_o | output | 1 | Committed PLL enable |
| pll_mul_o | output | 5 | Committed multiplier |
| pll_div_o | output | 2 | Committed divider |
| clk_sel_o | output | 1 | 1 selects PLL clock at the glitch-free mux |

## Verification
The bench builds the block with its default field widths: a 5-bit multiplier and a 2-bit divider. At these widths every multiplier, divider and control-flag combination can be swept, 512 commits in all. Each commit is checked at the pins and through every readback address. Reserved bits are set in every write. The sweep is followed by directed runs of each feed-abort pattern, the idle-gap and re-arm cases, and lock toggling while the PLL is connected.

// File: rtl/pll_commit_pkg.sv
package pll_commit_pkg;
  localparam int ADDR_W = 2;
  localparam int DATA_W = 8;

  typedef enum logic [ADDR_W-1:0] {
    REG_CTRL = 2'd0,
    REG_CFG  = 2'd1,
    REG_FEED = 2'd2,
    REG_STAT = 2'd3
  } reg_addr_e;

  localparam logic [DATA_W-1:0] FEED_KEY_A = 8'hAA;
  localparam logic [DATA_W-1:0] FEED_KEY_B = 8'h55;

  localparam int EN_BIT  = 0;
  localparam int CON_BIT = 1;
endpackage

// File: rtl/pll_feed_seq.sv
module pll_feed_seq
  import pll_commit_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              commit_o
);
  logic feed_wr, armed_q, armed_d;

  assign feed_wr = req_i && we_i && (addr_i == REG_FEED);

  // any access re-evaluates the arm state; idle cycles keep it
  always_comb begin
    armed_d = armed_q;
    if (req_i) armed_d = feed_wr && (wdata_i == FEED_KEY_A);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed_q <= 1'b0;
    else         armed_q <= armed_d;
  end

  assign commit_o = armed_q && feed_wr && (wdata_i == FEED_KEY_B);

  p_key_second_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |-> (wdata_i == FEED_KEY_B) && we_i && (addr_i == REG_FEED));

  p_no_commit_after_read_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i) |=> !commit_o);
endmodule

// File: rtl/pll_shadow_regs.sv
module pll_shadow_regs
  import pll_commit_pkg::*;
#(
  parameter int MUL_W = 5,
  parameter int DIV_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_ctrl_i,
  input  logic              wr_cfg_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              commit_i,
  output logic              en_o,
  output logic              con_o,
  output logic [MUL_W-1:0]  mul_o,
  output logic [DIV_W-1:0]  div_o
);
  logic             sh_en_q, sh_con_q;
  logic [MUL_W-1:0] sh_mul_q;
  logic [DIV_W-1:0] sh_div_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_en_q  <= 1'b0;
      sh_con_q <= 1'b0;
      sh_mul_q <= '0;
      sh_div_q <= '0;
    end else begin
      if (wr_ctrl_i) begin
        sh_en_q  <= wdata_i[EN_BIT];
        sh_con_q <= wdata_i[CON_BIT];
      end
      if (wr_cfg_i) begin
        sh_mul_q <= wdata_i[MUL_W-1:0];
        sh_div_q <= wdata_i[MUL_W +: DIV_W];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o  <= 1'b0;
      con_o <= 1'b0;
      mul_o <= '0;
      div_o <= '0;
    end else if (commit_i) begin
      en_o  <= sh_en_q;
      con_o <= sh_con_q;
      mul_o <= sh_mul_q;
      div_o <= sh_div_q;
    end
  end

  p_hold_without_commit_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit_i |=> $stable({en_o, con_o, mul_o, div_o}));
endmodule

// File: rtl/pll_clk_select.sv
module pll_clk_select (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic con_i,
  input  logic commit_i,
  output logic sel_o
);
  // registered on committed state; lock deliberately not an input
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sel_o <= 1'b0;
    else         sel_o <= en_i && con_i;
  end

  p_sel_only_after_commit_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_o != $past(sel_o)) |-> $past(commit_i, 2));

  p_sel_needs_enable_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_o |-> $past(en_i));
endmodule

// File: rtl/pll_commit_unit.sv
module pll_commit_unit
  import pll_commit_pkg::*;
#(
  parameter int MUL_W = 5,
  parameter int DIV_W = 2,
  parameter int RD_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [RD_W-1:0]   rdata_o,
  input  logic              lock_i,
  output logic              pll_en_o,
  output logic [MUL_W-1:0]  pll_mul_o,
  output logic [DIV_W-1:0]  pll_div_o,
  output logic              clk_sel_o
);
  localparam int STAT_W = 3 + MUL_W + DIV_W;

  logic commit, act_con;
  logic wr_ctrl, wr_cfg;

  assign wr_ctrl = req_i && we_i && (addr_i == REG_CTRL);
  assign wr_cfg  = req_i && we_i && (addr_i == REG_CFG);

  pll_feed_seq i_feed (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i,
    .commit_o (commit)
  );

  pll_shadow_regs #(.MUL_W(MUL_W), .DIV_W(DIV_W)) i_regs (
    .clk_i, .rst_ni,
    .wr_ctrl_i (wr_ctrl),
    .wr_cfg_i  (wr_cfg),
    .wdata_i,
    .commit_i  (commit),
    .en_o      (pll_en_o),
    .con_o     (act_con),
    .mul_o     (pll_mul_o),
    .div_o     (pll_div_o)
  );

  pll_clk_select i_sel (
    .clk_i, .rst_ni,
    .en_i     (pll_en_o),
    .con_i    (act_con),
    .commit_i (commit),
    .sel_o    (clk_sel_o)
  );

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      REG_CTRL: rdata_o = RD_W'({act_con, pll_en_o});
      REG_CFG:  rdata_o = RD_W'({pll_div_o, pll_mul_o});
      REG_STAT: rdata_o = RD_W'({lock_i, pll_div_o, pll_mul_o, act_con, pll_en_o});
      default:  rdata_o = '0;
    endcase
  end

  p_ctrl_reserved_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == REG_CTRL) |-> (rdata_o[RD_W-1:2] == '0));

  p_status_fits_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == REG_STAT) |-> (rdata_o >> STAT_W) == '0);
endmodule

// File: tb/test_pll_commit_unit.sv
module test_pll_commit_unit;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req = 1'b0, we = 1'b0, lock = 1'b0;
  logic [1:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic [15:0] rdata;
  logic        pll_en, clk_sel;
  logic [4:0]  pll_mul;
  logic [1:0]  pll_div;
  int n_run = 0, n_fail = 0;

  always #5 clk = ~clk;

  pll_commit_unit i_pll_commit_unit (
    .clk_i(clk), .rst_ni, .req_i(req), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .lock_i(lock), .pll_en_o(pll_en), .pll_mul_o(pll_mul),
    .pll_div_o(pll_div), .clk_sel_o(clk_sel)
  );

  task automatic chk(string r, int act, int exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", r, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk); req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(posedge clk);
  endtask

  task automatic rd(logic [1:0] a, output int v);
    @(negedge clk); req = 1'b1; we = 1'b0; addr = a;
    #1 v = int'(rdata);
    @(posedge clk);
  endtask

  task automatic idle();
    @(negedge clk); req = 1'b0; we = 1'b0;
  endtask

  task automatic feed();
    wr(2, 8'hAA); wr(2, 8'h55); idle();
  endtask

  // called at the negedge right after the commit edge (or later)
  task automatic expect_active(string r, int en, int con, int mul, int dv);
    int v;
    chk({r, " pll_en"}, pll_en, en);
    chk({r, " pll_mul"}, pll_mul, mul);
    chk({r, " pll_div"}, pll_div, dv);
    @(negedge clk);
    chk({r, " clk_sel"}, clk_sel, en & con);
    rd(0, v); chk({r, " rd ctrl"}, v, (con << 1) | en);
    rd(1, v); chk({r, " rd cfg"}, v, (dv << 5) | mul);
    rd(3, v); chk({r, " rd stat"}, v, (int'(lock) << 9) | (dv << 7) | (mul << 2) | (con << 1) | en);
    rd(2, v); chk({r, " rd feed"}, v, 0);
    idle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int v;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_ni = 1'b1;
    // R8 reset state, and shadow copies reset too
    expect_active("R8 reset", 0, 0, 0, 0);
    feed();
    expect_active("R8 shadow", 0, 0, 0, 0);

    // R1 R5 R6 R9: full sweep, reserved bits set on every write
    for (int c = 0; c < 4; c++)
      for (int m = 0; m < 32; m++)
        for (int d = 0; d < 4; d++) begin
          wr(0, 8'(8'hFC | c));
          wr(1, 8'(8'h80 | (d << 5) | m));
          feed();
          expect_active("R1 R5 R6 sweep", c & 1, c >> 1, m, d);
        end

    // R2: staged writes invisible before commit
    wr(0, 8'h01); wr(1, 8'h05); idle();
    chk("R2 en held", pll_en, 1);
    expect_active("R2 staged", 1, 1, 31, 3);

    // R4 aborts
    wr(2, 8'hAA); wr(0, 8'h01); wr(2, 8'h55); idle();
    expect_active("R4 other write", 1, 1, 31, 3);
    wr(2, 8'hAA); wr(2, 8'h54); wr(2, 8'h55); idle();
    expect_active("R4 bad key", 1, 1, 31, 3);
    wr(2, 8'hAA); rd(1, v); wr(2, 8'h55); idle();
    expect_active("R4 read between", 1, 1, 31, 3);
    wr(2, 8'h55); idle();
    expect_active("R4 lone key", 1, 1, 31, 3);

    // R3 re-arm and idle gap
    wr(2, 8'hAA); wr(2, 8'hAA); wr(2, 8'h55); idle();
    expect_active("R3 rearm", 1, 0, 5, 0);
    wr(0, 8'h03); wr(1, 8'h6A);
    wr(2, 8'hAA); idle(); repeat (3) @(negedge clk);
    wr(2, 8'h55); idle();
    expect_active("R3 idle gap", 1, 1, 10, 3);

    // R7 lock toggling has no effect
    for (int k = 0; k < 6; k++) begin
      @(negedge clk); lock = ~lock;
      @(negedge clk);
      chk("R7 clk_sel", clk_sel, 1);
      chk("R7 pll_en", pll_en, 1);
    end
    lock = 1'b1;
    expect_active("R7 lock stat", 1, 1, 10, 3);
    lock = 1'b0;
    wr(0, 8'h02); feed();
    expect_active("R6 connect only", 0, 1, 10, 3);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule